// File: doc/BRIEF.md
# Framed Response Port Receiver

This block is a host-side sequencer that pulls one response packet out of a device that exposes a byte-wide port with two addresses: a status address and a data address. After a start pulse it polls the status byte, checks an opening marker byte, copies payload bytes into a local buffer through a plain address/data/write-enable port, and checks a closing marker byte. Both markers are announced in-band by a flag bit in the status byte, and that flag can also cut the payload short.

While the payload streams in, bytes at buffer positions 2 through 5 are gathered into a 32-bit big-endian packet size, which is then compared with the buffer capacity given at start. At the end of every transfer, successful or not, the block pulses `done` for one cycle. In that cycle it presents the number of payload bytes stored, the decoded size and an error code. Every wait on a status bit is bounded by a fixed number of polls, so a silent device can never hang the sequencer.

Top module: `rxp_resp_rx`

## Requirements
- R1: If `max_len` is below 6 when a start is accepted, the very next cycle shows `done` with error code 1 (short buffer) and a byte count of 0, and no port read is issued.
- R2: The block first waits for the marker flag (status bit 2) and then reads the data address. A value other than 0x01 ends the transfer with error code 2 (bad start marker) and a byte count of 0.
- R3: For each payload slot the block waits for data-available (status bit 0). If the matching status sample also has bit 2 set, the payload phase ends with no data read. Otherwise one data read is made and the byte is written to buffer address equal to the slot index, starting at 0.
- R4: After `max_len` payload bytes the payload phase ends. If the flag was not seen, the block waits for status bit 2 and then reads the closing marker.
- R5: A closing marker value other than 0x03 ends the transfer with error code 5 (bad end marker).
- R6: `pkt_size` is bytes 2, 3, 4 and 5 of the buffer taken as a big-endian word, with byte 2 as the most significant. Bytes that never arrive count as zero.
- R7: After a good closing marker, `max_len` smaller than `pkt_size` gives error code 6 (oversize packet). Equal or larger gives code 0.
- R8: Each status wait makes at most POLL_LIMIT+1 status reads, the first at once. If none match, the transfer ends with error code 3 in a payload-slot wait and error code 4 in a marker wait.
- R9: Each accepted start produces exactly one single-cycle `done` that carries `byte_cnt`, `pkt_size` and `err_code`. A start seen while a transfer is running is ignored.
- R10: `port_rd` is a single-cycle request with `port_sel` 1 for status and 0 for data. `port_rdata` is taken in the cycle after the request. A data read consumes the device byte, and no two requests are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a receive transfer when idle |
| max_len | input | LEN_W | Buffer capacity in bytes |
| port_rd | output | 1 | Device port read request |
| port_sel | output | 1 | 1 selects status, 0 selects data |
| port_rdata | input | 8 | Device read data, valid the cycle after a request |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | LEN_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle end-of-transfer pulse |
| byte_cnt | output | LEN_W | Payload bytes stored |
| pkt_size | output | 32 | Decoded big-endian packet size |
| err_code | output | 3 | 0 ok, 1 short, 2 bad start, 3 data timeout, 4 flag timeout, 5 bad end, 6 oversize |

## Verification
The bench builds the block with LEN_W = 6 and POLL_LIMIT = 4. A timeout then takes only five status reads, so stalls of four and five polls can be put on every packet entry in turn, which places each wait exactly on either side of its limit. The small length width also makes it cheap to sweep the buffer capacity across the short-buffer threshold, the payload length across the capacity, and the embedded size across the capacity. A behavioural device model with per-entry stalls drives the port, and a protocol predictor in the bench computes the error code, byte count, size and buffer contents.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [2:0] {
    RX_OK        = 3'd0,
    RX_SHORT     = 3'd1,
    RX_BAD_START = 3'd2,
    RX_DATA_TO   = 3'd3,
    RX_FLAG_TO   = 3'd4,
    RX_BAD_END   = 3'd5,
    RX_OVERSIZE  = 3'd6
  } rx_err_e;

  localparam int          STAT_AVAIL_BIT = 0;
  localparam int          STAT_FLAG_BIT  = 2;
  localparam logic [7:0]  MASK_AVAIL     = 8'h01;
  localparam logic [7:0]  MASK_FLAG      = 8'h04;
  localparam logic [7:0]  CODE_OPEN      = 8'h01;
  localparam logic [7:0]  CODE_CLOSE     = 8'h03;
  localparam int          MIN_LEN        = 6;
  localparam int          SIZE_FIRST     = 2;
  localparam int          SIZE_BYTES     = 4;
endpackage

// File: rtl/rxp_port_if.sv
module rxp_port_if (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       rd_sel,
  output logic       port_rd,
  output logic       port_sel,
  input  logic [7:0] port_rdata,
  output logic       rsp_valid,
  output logic       rsp_sel,
  output logic [7:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port_rd   <= 1'b0;
      port_sel  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_sel   <= 1'b0;
    end else begin
      port_rd   <= rd_req;
      if (rd_req) port_sel <= rd_sel;
      rsp_valid <= port_rd;
      rsp_sel   <= port_sel;
    end
  end

  assign rsp_data = port_rdata;

  AST_PORT_GAP: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> !port_rd) else $error("back to back port request"); // R10
endmodule

// File: rtl/rxp_stat_wait.sv
module rxp_stat_wait #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] mask,
  input  logic [7:0] match,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic       rd_req,
  output logic       hit,
  output logic       tmo,
  output logic       flag_seen
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {SW_IDLE, SW_ISSUE, SW_WAIT} sw_state_e;

  sw_state_e        st;
  logic [CNT_W-1:0] polls;
  logic [7:0]       mask_q;
  logic [7:0]       match_q;

  assign rd_req = (st == SW_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SW_IDLE;
      polls     <= '0;
      mask_q    <= '0;
      match_q   <= '0;
      hit       <= 1'b0;
      tmo       <= 1'b0;
      flag_seen <= 1'b0;
    end else begin
      hit <= 1'b0;
      tmo <= 1'b0;
      unique case (st)
        SW_IDLE: if (go) begin
          polls   <= '0;
          mask_q  <= mask;
          match_q <= match;
          st      <= SW_ISSUE;
        end
        SW_ISSUE: st <= SW_WAIT;
        SW_WAIT: if (rsp_valid) begin
          flag_seen <= rsp_data[rxp_pkg::STAT_FLAG_BIT];
          if ((rsp_data & mask_q) == match_q) begin
            hit <= 1'b1;
            st  <= SW_IDLE;
          end else if (polls == CNT_W'(POLL_LIMIT)) begin
            tmo <= 1'b1;
            st  <= SW_IDLE;
          end else begin
            polls <= polls + 1'b1;
            st    <= SW_ISSUE;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    polls <= CNT_W'(POLL_LIMIT)) else $error("poll count past limit"); // R8
  AST_HIT_XOR_TMO: assert property (@(posedge clk) disable iff (rst)
    !(hit && tmo)) else $error("wait ended both ways"); // R8
endmodule

// File: rtl/rxp_size_cap.sv
module rxp_size_cap #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [LEN_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic [31:0]      size
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      size <= '0;
    end else if (wr) begin
      for (int k = 0; k < rxp_pkg::SIZE_BYTES; k++) begin
        if (idx == LEN_W'(rxp_pkg::SIZE_FIRST + k))
          size[8*(rxp_pkg::SIZE_BYTES-1-k) +: 8] <= wbyte;
      end
    end
  end
endmodule

// File: rtl/rxp_resp_rx.sv
module rxp_resp_rx #(
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] max_len,
  output logic             port_rd,
  output logic             port_sel,
  input  logic [7:0]       port_rdata,
  output logic             buf_we,
  output logic [LEN_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  output logic             done,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [31:0]      pkt_size,
  output logic [2:0]       err_code
);
  import rxp_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_WOPEN, S_ROPEN_REQ, S_ROPEN_RSP, S_WAVAIL,
    S_RDATA_REQ, S_RDATA_RSP, S_WCLOSE, S_RCLOSE_REQ, S_RCLOSE_RSP
  } rx_state_e;

  rx_state_e        st;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [LEN_W-1:0] max_q;
  rx_err_e          err_q;
  logic             done_q;
  logic             we_q;
  logic [LEN_W-1:0] addr_q;
  logic [7:0]       wdata_q;
  logic             sw_go_q;
  logic [7:0]       sw_mask;
  logic             sw_rd_req;
  logic             sw_hit;
  logic             sw_tmo;
  logic             sw_flag;
  logic             data_req;
  logic             rsp_valid;
  logic             rsp_sel;
  logic [7:0]       rsp_data;
  logic             data_rsp;
  logic             accept;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign data_req = (st == S_ROPEN_REQ) || (st == S_RDATA_REQ) || (st == S_RCLOSE_REQ);
  assign data_rsp = rsp_valid && !rsp_sel;
  assign sw_mask  = (st == S_WAVAIL) ? MASK_AVAIL : MASK_FLAG;
  assign accept   = (st == S_IDLE) && start;

  rxp_port_if u_port (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (sw_rd_req | data_req),
    .rd_sel     (sw_rd_req),
    .port_rd    (port_rd),
    .port_sel   (port_sel),
    .port_rdata (port_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_sel    (rsp_sel),
    .rsp_data   (rsp_data)
  );

  rxp_stat_wait #(.POLL_LIMIT(POLL_LIMIT)) u_wait (
    .clk       (clk),
    .rst       (rst),
    .go        (sw_go_q),
    .mask      (sw_mask),
    .match     (sw_mask),
    .rsp_valid (rsp_valid && rsp_sel),
    .rsp_data  (rsp_data),
    .rd_req    (sw_rd_req),
    .hit       (sw_hit),
    .tmo       (sw_tmo),
    .flag_seen (sw_flag)
  );

  rxp_size_cap #(.LEN_W(LEN_W)) u_size (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .wr    (we_q),
    .idx   (addr_q),
    .wbyte (wdata_q),
    .size  (pkt_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt_q   <= '0;
      max_q   <= '0;
      err_q   <= RX_OK;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      sw_go_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      sw_go_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          max_q <= max_len;
          cnt_q <= '0;
          if (max_len < LEN_W'(MIN_LEN)) begin
            err_q  <= RX_SHORT;
            done_q <= 1'b1;
          end else begin
            sw_go_q <= 1'b1;
            st      <= S_WOPEN;
          end
        end
        S_WOPEN: begin
          if (sw_hit) st <= S_ROPEN_REQ;
          else if (sw_tmo) begin
            err_q <= RX_FLAG_TO; done_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_ROPEN_REQ: st <= S_ROPEN_RSP;
        S_ROPEN_RSP: if (data_rsp) begin
          if (rsp_data == CODE_OPEN) begin
            sw_go_q <= 1'b1;
            st      <= S_WAVAIL;
          end else begin
            err_q <= RX_BAD_START; done_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_WAVAIL: begin
          if (sw_hit) st <= sw_flag ? S_RCLOSE_REQ : S_RDATA_REQ;
          else if (sw_tmo) begin
            err_q <= RX_DATA_TO; done_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_RDATA_REQ: st <= S_RDATA_RSP;
        S_RDATA_RSP: if (data_rsp) begin
          we_q    <= 1'b1;
          addr_q  <= cnt_q;
          wdata_q <= rsp_data;
          cnt_q   <= cnt_nxt;
          sw_go_q <= 1'b1;
          st      <= (cnt_nxt == max_q) ? S_WCLOSE : S_WAVAIL;
        end
        S_WCLOSE: begin
          if (sw_hit) st <= S_RCLOSE_REQ;
          else if (sw_tmo) begin
            err_q <= RX_FLAG_TO; done_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_RCLOSE_REQ: st <= S_RCLOSE_RSP;
        S_RCLOSE_RSP: if (data_rsp) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (rsp_data != CODE_CLOSE)                    err_q <= RX_BAD_END;
          else if ({{(32-LEN_W){1'b0}}, max_q} < pkt_size) err_q <= RX_OVERSIZE;
          else                                           err_q <= RX_OK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign byte_cnt  = cnt_q;
  assign err_code  = err_q;
  assign buf_we    = we_q;
  assign buf_addr  = addr_q;
  assign buf_wdata = wdata_q;

  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && max_len < LEN_W'(MIN_LEN)) |=> (done && err_code == RX_SHORT)) else $error("short buffer not rejected"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_WRITE_BOUND: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> buf_addr < max_q) else $error("write past buffer"); // R4
  AST_OK_FITS: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == RX_OK) |-> {{(32-LEN_W){1'b0}}, max_q} >= pkt_size) else $error("oversize reported ok"); // R7
  AST_SHORT_NO_PORT: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sw_rd_req) else $error("status read while idle"); // R1
endmodule

// File: tb/rxp_resp_rx_tb_top.sv
module rxp_resp_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 6;
  localparam int PL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [LW-1:0] max_len = '0;
  logic          port_rd, port_sel;
  logic [7:0]    port_rdata = 8'h00;
  logic          buf_we;
  logic [LW-1:0] buf_addr;
  logic [7:0]    buf_wdata;
  logic          done;
  logic [LW-1:0] byte_cnt;
  logic [31:0]   pkt_size;
  logic [2:0]    err_code;

  int checks = 0;
  int errors = 0;

  rxp_resp_rx #(.LEN_W(LW), .POLL_LIMIT(PL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .max_len(max_len),
    .port_rd(port_rd), .port_sel(port_sel), .port_rdata(port_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .done(done), .byte_cnt(byte_cnt), .pkt_size(pkt_size), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // device model: entries with per-entry stall polls
  logic [7:0] dev_byte [64];
  bit         dev_mark [64];
  int         dev_st   [64];
  int         dev_n = 0, dev_p = 0, dev_stall = 0;

  always @(posedge clk) begin
    if (port_rd) begin
      if (port_sel) begin
        if (dev_stall > 0) begin
          port_rdata <= 8'h00;
          dev_stall  <= dev_stall - 1;
        end else if (dev_p < dev_n)
          port_rdata <= {5'b0, dev_mark[dev_p], 1'b0, 1'b1};
        else
          port_rdata <= 8'h00;
      end else begin
        port_rdata <= (dev_p < dev_n) ? dev_byte[dev_p] : 8'hFF;
        dev_stall  <= (dev_p + 1 < 64) ? dev_st[dev_p + 1] : 0;
        dev_p      <= dev_p + 1;
      end
    end
  end

  logic [7:0] mem [64];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  int  n_rd = 0, n_done = 0;
  bit  b2b = 1'b0, prev_rd = 1'b0;
  always @(negedge clk) begin
    if (port_rd) n_rd++;
    if (done) n_done++;
    if (port_rd && prev_rd) b2b = 1'b1;
    prev_rd = port_rd;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(int len, logic [31:0] sz, logic [7:0] oc, logic [7:0] cc);
    for (int i = 0; i < 64; i++) begin
      dev_st[i] = 0; dev_mark[i] = 1'b0; dev_byte[i] = 8'h00;
    end
    dev_n = len + 2;
    dev_byte[0] = oc; dev_mark[0] = 1'b1;
    for (int i = 0; i < len; i++)
      dev_byte[1+i] = (i >= 2 && i <= 5) ? sz[8*(5-i) +: 8] : 8'(i*7 + 3);
    dev_byte[len+1] = cc; dev_mark[len+1] = 1'b1;
  endtask

  int          exp_err, exp_cnt;
  logic [31:0] exp_size;

  task automatic predict(int ml);
    int p, c; bit f;
    exp_cnt = 0; exp_size = 0; exp_err = 0;
    if (ml < 6) begin exp_err = 1; return; end
    p = 0;
    if (!(p < dev_n && dev_mark[p] && dev_st[p] <= PL)) begin exp_err = 4; return; end
    if (dev_byte[p] != 8'h01) begin exp_err = 2; return; end
    p++; c = 0; f = 1'b0;
    while (c < ml) begin
      if (!(p < dev_n && dev_st[p] <= PL)) begin exp_err = 3; return; end
      if (dev_mark[p]) begin f = 1'b1; break; end
      if (c >= 2 && c <= 5) exp_size[8*(5-c) +: 8] = dev_byte[p];
      c++; exp_cnt = c; p++;
    end
    if (!f && !(p < dev_n && dev_mark[p] && dev_st[p] <= PL)) begin exp_err = 4; return; end
    if (dev_byte[p] != 8'h03) exp_err = 5;
    else if (32'(ml) < exp_size) exp_err = 6;
    else exp_err = 0;
  endtask

  task automatic run(int ml, string req, bit restart = 1'b0);
    int w; bit got; int g_err, g_cnt; logic [31:0] g_size;
    predict(ml);
    for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
    dev_p = 0; dev_stall = dev_st[0];
    @(negedge clk); n_rd = 0; n_done = 0;
    start = 1'b1; max_len = LW'(ml);
    @(negedge clk); start = 1'b0;
    got = done; g_err = err_code; g_cnt = byte_cnt; g_size = pkt_size;
    w = 0;
    while (!got && w < 2000) begin
      if (restart && w == 6) begin start = 1'b1; max_len = LW'(2); end
      else start = 1'b0;
      @(negedge clk); w++;
      if (done) begin got = 1'b1; g_err = err_code; g_cnt = byte_cnt; g_size = pkt_size; end
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(got, req, "done seen", got, 1);
    chk(g_err == exp_err, req, "err_code", g_err, exp_err);
    chk(g_cnt == exp_cnt, req, "byte_cnt", g_cnt, exp_cnt);
    chk(g_size == exp_size, "R6", "pkt_size", g_size, exp_size);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < exp_cnt; i++) if (mem[i] != dev_byte[1+i]) ok = 1'b0;
      chk(ok, "R3", "buffer contents", ok, 1);
    end
    chk(n_done == 1, "R9", "done pulses", n_done, 1);
    if (exp_err == 1) chk(n_rd == 0, "R1", "port reads", n_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !buf_we && !port_rd && err_code == 3'd0, "R9", "reset outputs",
        {done, buf_we, port_rd, err_code}, 0);

    // capacity sweep across the short threshold (R1, R4 boundary L == max)
    build(6, 32'd6, 8'h01, 8'h03);
    for (int ml = 0; ml <= 9; ml++) run(ml, ml < 6 ? "R1" : "R4");

    // payload length sweep around capacity 10 (R3, R4, R6)
    for (int len = 0; len <= 13; len++) begin
      build(len, 32'h0000_0009, 8'h01, 8'h03);
      run(10, len > 10 ? "R4" : "R3");
    end
    build(4, 32'h0A0B_0000, 8'h01, 8'h03);
    run(8, "R6");

    // embedded size swept across capacity (R7)
    for (int s = 7; s <= 13; s++) begin
      build(8, 32'(s), 8'h01, 8'h03);
      run(10, "R7");
    end
    build(8, 32'h0100_0000, 8'h01, 8'h03);
    run(10, "R7");

    // marker codes (R2, R5)
    build(6, 32'd6, 8'h02, 8'h03); run(8, "R2");
    build(6, 32'd6, 8'h01, 8'h05); run(8, "R5");
    build(6, 32'd6, 8'h01, 8'h03); dev_mark[0] = 1'b0; run(8, "R2");

    // stall sweep over every entry, at and past the poll limit (R8)
    for (int k = 0; k <= 7; k++)
      for (int sv = PL; sv <= PL + 1; sv++)
        for (int ml = 6; ml <= 8; ml += 2) begin
          build(6, 32'd6, 8'h01, 8'h03);
          dev_st[k] = sv;
          run(ml, "R8");
        end

    // start while busy is ignored (R9)
    build(9, 32'd9, 8'h01, 8'h03);
    run(12, "R9", 1'b1);

    chk(!b2b, "R10", "back to back port reads", b2b, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule